// File: doc/BRIEF.md
# MESI Snooping Cache Coherence Controller

This block is the coherence controller for a small direct-mapped write-back cache. The cache sits on an atomic shared bus next to other caches and a main memory. Each line holds one data word. The controller keeps a tag, a state and the data for every line. It serves one processor request at a time, and the processor stays stalled until that request completes. When the processor needs bus help, the controller raises a bus request. After the grant it issues a read, a read-for-ownership or a writeback. It then waits for the acknowledge, and holds the command steady until the acknowledge arrives.

A second lookup port follows the reads and read-for-ownership transactions that other caches put on the bus. Within the same cycle it answers with a shared indication and, when it holds the only dirty copy, with a flush of that data. It also downgrades or invalidates its own copy.

A read miss installs the line as exclusive-clean when no other cache reports a copy. A later write to that line then needs no bus traffic at all.

Top module: `mesi_snoop_ctrl`

## Requirements
- R1: After reset every line is Invalid. `cpu_done_o` and `bus_req_o` are low, and no snoop gets a shared or flush answer.
- R2: A processor read that misses issues a read command (`bus_cmd_o` = 2'b01) and returns the word from memory. The line is filled as Exclusive if `bus_shared_i` is low at the acknowledge, and as Shared if it is high. A later read of the line hits with no bus traffic.
- R3: A processor write to an Exclusive or Modified line completes with no bus transaction. The line becomes Modified.
- R4: A processor write to an Invalid, absent or Shared line first issues a read-for-ownership (`bus_cmd_o` = 2'b10). The line then becomes Modified and holds the written word.
- R5: A snooped read (`snp_cmd_i` = 2'b01) that hits a Modified line drives `snp_flush_o` with the line's word on `snp_data_o` and asserts `snp_shared_o`. The line drops to Shared.
- R6: A snooped read-for-ownership (`snp_cmd_i` = 2'b10) that hits a Modified line flushes it and invalidates it. If it hits an Exclusive or Shared line, it invalidates the line without a flush.
- R7: `snp_shared_o` is asserted exactly when a snooped read hits a valid line. A snooped read that hits an Exclusive line moves it to Shared. Misses and read-for-ownership snoops never assert it.
- R8: A fill whose victim line is Modified under another tag is preceded by a writeback (`bus_cmd_o` = 2'b11) that carries the victim's address and word. A victim that is Exclusive or Shared is dropped with no bus transaction.
- R9: Only one request is in flight. `cpu_done_o` is a one-cycle pulse that follows an accepted request. `cpu_rdata_o` carries the read word while `cpu_done_o` is high. A hit completes one cycle after it is accepted.
- R10: `bus_req_o` stays high from the request until the final acknowledge. A command on `bus_cmd_o` only appears while the request is high. The command and `bus_addr_o` hold until `bus_ack_i`.
- R11: When a snoop and a processor request touch the same line in the same cycle, the snoop's state change takes effect. The processor request is re-examined one cycle later against the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_i | input | 1 | Processor request, held until done |
| cpu_we_i | input | 1 | 1 = write, 0 = read |
| cpu_addr_i | input | ADDR_W | Word address of the request |
| cpu_wdata_i | input | DATA_W | Write word |
| cpu_done_o | output | 1 | One-cycle completion pulse |
| cpu_rdata_o | output | DATA_W | Read word, valid with done |
| bus_req_o | output | 1 | Bus request to arbiter |
| bus_gnt_i | input | 1 | Bus grant |
| bus_cmd_o | output | 2 | 00 idle, 01 read, 10 read-for-ownership, 11 writeback |
| bus_addr_o | output | ADDR_W | Transaction address |
| bus_wdata_o | output | DATA_W | Writeback word |
| bus_ack_i | input | 1 | Transaction complete |
| bus_rdata_i | input | DATA_W | Fill word from memory, with ack |
| bus_shared_i | input | 1 | Wired-OR shared line from other caches, with ack |
| snp_valid_i | input | 1 | Another cache's transaction is on the bus |
| snp_cmd_i | input | 2 | Snooped command, same encoding as bus_cmd_o |
| snp_addr_i | input | ADDR_W | Snooped address |
| snp_shared_o | output | 1 | This cache holds a copy (to wired-OR) |
| snp_flush_o | output | 1 | This cache supplies dirty data |
| snp_data_o | output | DATA_W | Flushed word |

## Verification
The bench goes after the transitions that save or cost bus traffic. One is a write right after an exclusive fill, which must stay silent; a design that ignored the shared line would issue a needless read-for-ownership. Another is a write to a Shared line, which must ask for ownership; a design that wrote it silently would leave stale copies in other caches. The bench also checks that dirty victims are written back before a fill with the old address and data. A design that dropped them would lose writes, and one that also wrote back clean victims would add traffic. The case of a snoop and a processor write on the same line in one cycle must end in a read-for-ownership, because a design that let the processor's update win would leave a Modified line while another cache believes it shares it.

// File: rtl/mesi_pkg.sv
package mesi_pkg;
   typedef enum logic [1:0] {
      LN_I = 2'b00,
      LN_S = 2'b01,
      LN_E = 2'b10,
      LN_M = 2'b11
   } line_st_e;

   typedef enum logic [1:0] {
      BC_NONE = 2'b00,
      BC_RD   = 2'b01,
      BC_RDX  = 2'b10,
      BC_WB   = 2'b11
   } bus_cmd_e;

   typedef enum logic [1:0] {
      F_IDLE = 2'b00,
      F_ARB  = 2'b01,
      F_XFER = 2'b10,
      F_RESP = 2'b11
   } fsm_e;
endpackage

// File: rtl/mesi_line_store.sv
module mesi_line_store
   import mesi_pkg::*;
#(
   parameter int LINES         = 8,
   parameter int TAG_W         = 7,
   parameter int DATA_W        = 32,
   parameter bit CLEAR_PAYLOAD = 1'b0,
   localparam int IDX_W        = $clog2(LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   // processor-side port
   input  logic [IDX_W-1:0]  p_idx_i,
   output logic [TAG_W-1:0]  p_tag_o,
   output line_st_e          p_st_o,
   output logic [DATA_W-1:0] p_data_o,
   input  logic              p_we_i,
   input  logic [TAG_W-1:0]  p_tag_i,
   input  line_st_e          p_st_i,
   input  logic [DATA_W-1:0] p_data_i,
   // snoop-side port
   input  logic [IDX_W-1:0]  s_idx_i,
   output logic [TAG_W-1:0]  s_tag_o,
   output line_st_e          s_st_o,
   output logic [DATA_W-1:0] s_data_o,
   input  logic              s_we_i,
   input  line_st_e          s_st_i
);
   line_st_e          st_arr   [LINES];
   logic [TAG_W-1:0]  tag_arr  [LINES];
   logic [DATA_W-1:0] data_arr [LINES];

   for (genvar i = 0; i < LINES; i++) begin : g_line
      line_st_e          st_q;
      logic [TAG_W-1:0]  tag_q;
      logic [DATA_W-1:0] data_q;
      logic              p_sel, s_sel;

      assign p_sel = p_we_i && (p_idx_i == IDX_W'(i));
      assign s_sel = s_we_i && (s_idx_i == IDX_W'(i));

      // snoop update wins over processor update on the state field
      always_ff @(posedge clk) begin
         if (!rst_n) st_q <= LN_I;
         else if (s_sel) st_q <= s_st_i;
         else if (p_sel) st_q <= p_st_i;
      end

      if (CLEAR_PAYLOAD) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               tag_q  <= '0;
               data_q <= '0;
            end else if (p_sel) begin
               tag_q  <= p_tag_i;
               data_q <= p_data_i;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (p_sel) begin
               tag_q  <= p_tag_i;
               data_q <= p_data_i;
            end
         end
      end

      assign st_arr[i]   = st_q;
      assign tag_arr[i]  = tag_q;
      assign data_arr[i] = data_q;
   end

   assign p_st_o   = st_arr[p_idx_i];
   assign p_tag_o  = tag_arr[p_idx_i];
   assign p_data_o = data_arr[p_idx_i];
   assign s_st_o   = st_arr[s_idx_i];
   assign s_tag_o  = tag_arr[s_idx_i];
   assign s_data_o = data_arr[s_idx_i];
endmodule

// File: rtl/mesi_snoop_unit.sv
module mesi_snoop_unit
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 3,
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              snp_valid_i,
   input  logic [1:0]        snp_cmd_i,
   input  logic [ADDR_W-1:0] snp_addr_i,
   output logic [IDX_W-1:0]  s_idx_o,
   input  logic [TAG_W-1:0]  s_tag_i,
   input  line_st_e          s_st_i,
   input  logic [DATA_W-1:0] s_data_i,
   output logic              s_we_o,
   output line_st_e          s_st_o,
   output logic              shared_o,
   output logic              flush_o,
   output logic [DATA_W-1:0] flush_data_o
);
   logic     is_rd, is_rdx, hit;
   line_st_e nxt;

   assign s_idx_o = snp_addr_i[IDX_W-1:0];
   assign is_rd   = snp_valid_i && (bus_cmd_e'(snp_cmd_i) == BC_RD);
   assign is_rdx  = snp_valid_i && (bus_cmd_e'(snp_cmd_i) == BC_RDX);
   assign hit     = (s_st_i != LN_I) && (s_tag_i == snp_addr_i[ADDR_W-1:IDX_W]);

   always_comb begin
      nxt = s_st_i;
      if (hit && is_rd)  nxt = LN_S;
      if (hit && is_rdx) nxt = LN_I;
   end

   assign s_st_o       = nxt;
   assign s_we_o       = hit && (is_rd || is_rdx) && (nxt != s_st_i);
   assign shared_o     = hit && is_rd;
   assign flush_o      = hit && (is_rd || is_rdx) && (s_st_i == LN_M);
   assign flush_data_o = flush_o ? s_data_i : '0;
endmodule

// File: rtl/mesi_proc_fsm.sv
module mesi_proc_fsm
   import mesi_pkg::*;
#(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32,
   parameter int IDX_W  = 3,
   localparam int TAG_W = ADDR_W - IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_i,
   input  logic              cpu_we_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   input  logic [DATA_W-1:0] cpu_wdata_i,
   output logic              cpu_done_o,
   output logic [DATA_W-1:0] cpu_rdata_o,
   output logic              bus_req_o,
   input  logic              bus_gnt_i,
   output bus_cmd_e          bus_cmd_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic              bus_ack_i,
   input  logic [DATA_W-1:0] bus_rdata_i,
   input  logic              bus_shared_i,
   input  logic              conflict_i,
   output logic [IDX_W-1:0]  p_idx_o,
   input  logic [TAG_W-1:0]  p_tag_i,
   input  line_st_e          p_st_i,
   input  logic [DATA_W-1:0] p_data_i,
   output logic              p_we_o,
   output logic [TAG_W-1:0]  p_tag_o,
   output line_st_e          p_st_o,
   output logic [DATA_W-1:0] p_data_o
);
   fsm_e              fsm_q, fsm_d;
   logic              we_q;
   logic [ADDR_W-1:0] addr_q, xaddr_q;
   logic [DATA_W-1:0] wdata_q, xdata_q, rdata_q;
   bus_cmd_e          cmd_q;

   logic [ADDR_W-1:0] cur_addr;
   logic [TAG_W-1:0]  cur_tag;
   logic              hit, owned, victim_dirty, accept;

   assign cur_addr     = (fsm_q == F_IDLE) ? cpu_addr_i : addr_q;
   assign cur_tag      = cur_addr[ADDR_W-1:IDX_W];
   assign p_idx_o      = cur_addr[IDX_W-1:0];
   assign hit          = (p_st_i != LN_I) && (p_tag_i == cur_tag);
   assign owned        = (p_st_i == LN_E) || (p_st_i == LN_M);
   assign victim_dirty = (p_st_i == LN_M) && (p_tag_i != cur_tag);
   assign accept       = (fsm_q == F_IDLE) && cpu_req_i && !conflict_i;

   always_comb begin
      fsm_d    = fsm_q;
      p_we_o   = 1'b0;
      p_tag_o  = cur_tag;
      p_st_o   = LN_M;
      p_data_o = cpu_wdata_i;
      unique case (fsm_q)
         F_IDLE: begin
            if (accept) begin
               if (hit && !cpu_we_i) begin
                  fsm_d = F_RESP;
               end else if (hit && owned) begin
                  p_we_o = 1'b1;
                  fsm_d  = F_RESP;
               end else begin
                  fsm_d = F_ARB;
               end
            end
         end
         F_ARB: begin
            if (bus_gnt_i) fsm_d = F_XFER;
         end
         F_XFER: begin
            if (bus_ack_i) begin
               p_we_o = 1'b1;
               if (cmd_q == BC_WB) begin
                  p_tag_o  = p_tag_i;
                  p_st_o   = LN_I;
                  p_data_o = p_data_i;
                  fsm_d    = F_ARB;
               end else begin
                  p_st_o   = (cmd_q == BC_RDX) ? LN_M : (bus_shared_i ? LN_S : LN_E);
                  p_data_o = we_q ? wdata_q : bus_rdata_i;
                  fsm_d    = F_RESP;
               end
            end
         end
         default: fsm_d = F_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fsm_q   <= F_IDLE;
         we_q    <= 1'b0;
         addr_q  <= '0;
         wdata_q <= '0;
         cmd_q   <= BC_NONE;
         xaddr_q <= '0;
         xdata_q <= '0;
         rdata_q <= '0;
      end else begin
         fsm_q <= fsm_d;
         if (accept) begin
            we_q    <= cpu_we_i;
            addr_q  <= cpu_addr_i;
            wdata_q <= cpu_wdata_i;
            if (hit && !cpu_we_i) rdata_q <= p_data_i;
         end
         if (fsm_q == F_ARB && bus_gnt_i) begin
            // decide the command at grant time, after any snoop downgrade
            if (victim_dirty) begin
               cmd_q   <= BC_WB;
               xaddr_q <= {p_tag_i, p_idx_o};
               xdata_q <= p_data_i;
            end else begin
               cmd_q   <= we_q ? BC_RDX : BC_RD;
               xaddr_q <= addr_q;
            end
         end
         if (fsm_q == F_XFER && bus_ack_i && cmd_q != BC_WB) rdata_q <= bus_rdata_i;
      end
   end

   assign bus_req_o   = (fsm_q == F_ARB) || (fsm_q == F_XFER);
   assign bus_cmd_o   = (fsm_q == F_XFER) ? cmd_q : BC_NONE;
   assign bus_addr_o  = xaddr_q;
   assign bus_wdata_o = xdata_q;
   assign cpu_done_o  = (fsm_q == F_RESP);
   assign cpu_rdata_o = rdata_q;
endmodule

// File: rtl/mesi_snoop_ctrl.sv
module mesi_snoop_ctrl
   import mesi_pkg::*;
#(
   parameter int ADDR_W        = 10,
   parameter int DATA_W        = 32,
   parameter int LINES         = 8,
   parameter bit CLEAR_PAYLOAD = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cpu_req_i,
   input  logic              cpu_we_i,
   input  logic [ADDR_W-1:0] cpu_addr_i,
   input  logic [DATA_W-1:0] cpu_wdata_i,
   output logic              cpu_done_o,
   output logic [DATA_W-1:0] cpu_rdata_o,
   output logic              bus_req_o,
   input  logic              bus_gnt_i,
   output logic [1:0]        bus_cmd_o,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   input  logic              bus_ack_i,
   input  logic [DATA_W-1:0] bus_rdata_i,
   input  logic              bus_shared_i,
   input  logic              snp_valid_i,
   input  logic [1:0]        snp_cmd_i,
   input  logic [ADDR_W-1:0] snp_addr_i,
   output logic              snp_shared_o,
   output logic              snp_flush_o,
   output logic [DATA_W-1:0] snp_data_o
);
   localparam int IDX_W = $clog2(LINES);
   localparam int TAG_W = ADDR_W - IDX_W;

   if (LINES < 2 || (1 << IDX_W) != LINES) begin : g_bad_lines
      $error("LINES must be a power of two of at least 2");
   end
   if (ADDR_W <= IDX_W) begin : g_bad_addr
      $error("ADDR_W must exceed the index width");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("DATA_W must be positive");
   end

   logic [IDX_W-1:0]  p_idx, s_idx;
   logic [TAG_W-1:0]  p_tag_r, p_tag_w, s_tag_r;
   line_st_e          p_st_r, p_st_w, s_st_r, s_st_w;
   logic [DATA_W-1:0] p_data_r, p_data_w, s_data_r;
   logic              p_we, s_we, conflict;
   bus_cmd_e          cmd;

   assign conflict  = s_we && (s_idx == p_idx);
   assign bus_cmd_o = cmd;

   mesi_line_store #(
      .LINES(LINES), .TAG_W(TAG_W), .DATA_W(DATA_W), .CLEAR_PAYLOAD(CLEAR_PAYLOAD)
   ) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .p_idx_i  (p_idx),
      .p_tag_o  (p_tag_r),
      .p_st_o   (p_st_r),
      .p_data_o (p_data_r),
      .p_we_i   (p_we),
      .p_tag_i  (p_tag_w),
      .p_st_i   (p_st_w),
      .p_data_i (p_data_w),
      .s_idx_i  (s_idx),
      .s_tag_o  (s_tag_r),
      .s_st_o   (s_st_r),
      .s_data_o (s_data_r),
      .s_we_i   (s_we),
      .s_st_i   (s_st_w)
   );

   mesi_snoop_unit #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) u_snoop (
      .snp_valid_i  (snp_valid_i),
      .snp_cmd_i    (snp_cmd_i),
      .snp_addr_i   (snp_addr_i),
      .s_idx_o      (s_idx),
      .s_tag_i      (s_tag_r),
      .s_st_i       (s_st_r),
      .s_data_i     (s_data_r),
      .s_we_o       (s_we),
      .s_st_o       (s_st_w),
      .shared_o     (snp_shared_o),
      .flush_o      (snp_flush_o),
      .flush_data_o (snp_data_o)
   );

   mesi_proc_fsm #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .IDX_W(IDX_W)
   ) u_fsm (
      .clk          (clk),
      .rst_n        (rst_n),
      .cpu_req_i    (cpu_req_i),
      .cpu_we_i     (cpu_we_i),
      .cpu_addr_i   (cpu_addr_i),
      .cpu_wdata_i  (cpu_wdata_i),
      .cpu_done_o   (cpu_done_o),
      .cpu_rdata_o  (cpu_rdata_o),
      .bus_req_o    (bus_req_o),
      .bus_gnt_i    (bus_gnt_i),
      .bus_cmd_o    (cmd),
      .bus_addr_o   (bus_addr_o),
      .bus_wdata_o  (bus_wdata_o),
      .bus_ack_i    (bus_ack_i),
      .bus_rdata_i  (bus_rdata_i),
      .bus_shared_i (bus_shared_i),
      .conflict_i   (conflict),
      .p_idx_o      (p_idx),
      .p_tag_i      (p_tag_r),
      .p_st_i       (p_st_r),
      .p_data_i     (p_data_r),
      .p_we_o       (p_we),
      .p_tag_o      (p_tag_w),
      .p_st_o       (p_st_w),
      .p_data_o     (p_data_w)
   );
endmodule

// File: rtl/mesi_snoop_ctrl_chk.sv
module mesi_snoop_ctrl_chk #(
   parameter int ADDR_W = 10,
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              cpu_req_i,
   input logic              cpu_done_o,
   input logic              bus_req_o,
   input logic [1:0]        bus_cmd_o,
   input logic [ADDR_W-1:0] bus_addr_o,
   input logic              bus_ack_i,
   input logic              snp_valid_i,
   input logic [1:0]        snp_cmd_i,
   input logic              snp_shared_o,
   input logic              snp_flush_o
);
   AST_SHARED_ONLY_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
      snp_shared_o |-> (snp_valid_i && snp_cmd_i == 2'b01)); // R7

   AST_FLUSH_NEEDS_SNOOP: assert property (@(posedge clk) disable iff (!rst_n)
      snp_flush_o |-> (snp_valid_i && (snp_cmd_i == 2'b01 || snp_cmd_i == 2'b10))); // R5

   AST_CMD_UNDER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd_o != 2'b00) |-> bus_req_o); // R10

   AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd_o != 2'b00 && !bus_ack_i) |=>
         (bus_cmd_o == $past(bus_cmd_o) && bus_addr_o == $past(bus_addr_o))); // R10

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done_o |=> !cpu_done_o); // R9

   AST_DONE_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_done_o |-> $past(cpu_req_i)); // R9

   AST_NO_DONE_MID_XFER: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd_o != 2'b00) |-> !cpu_done_o); // R9

   AST_WB_BEFORE_FILL: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_cmd_o == 2'b11 && bus_ack_i) |=> !cpu_done_o); // R8
endmodule

bind mesi_snoop_ctrl mesi_snoop_ctrl_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .cpu_req_i    (cpu_req_i),
   .cpu_done_o   (cpu_done_o),
   .bus_req_o    (bus_req_o),
   .bus_cmd_o    (bus_cmd_o),
   .bus_addr_o   (bus_addr_o),
   .bus_ack_i    (bus_ack_i),
   .snp_valid_i  (snp_valid_i),
   .snp_cmd_i    (snp_cmd_i),
   .snp_shared_o (snp_shared_o),
   .snp_flush_o  (snp_flush_o)
);

// File: tb/mesi_snoop_ctrl_tb.sv
`timescale 1ns/1ps
module mesi_snoop_ctrl_tb;
   localparam int AW = 10;
   localparam int DW = 32;
   localparam int NL = 8;
   localparam int IW = 3;
   localparam int TW = AW - IW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          cpu_req = 1'b0, cpu_we = 1'b0;
   logic [AW-1:0] cpu_addr = '0;
   logic [DW-1:0] cpu_wdata = '0;
   logic          cpu_done;
   logic [DW-1:0] cpu_rdata;
   logic          bus_req;
   logic          bus_gnt = 1'b0;
   logic [1:0]    bus_cmd;
   logic [AW-1:0] bus_addr;
   logic [DW-1:0] bus_wdata;
   logic          bus_ack = 1'b0;
   logic [DW-1:0] bus_rdata = '0;
   logic          bus_shared = 1'b0;
   logic          snp_valid = 1'b0;
   logic [1:0]    snp_cmd = 2'b00;
   logic [AW-1:0] snp_addr = '0;
   logic          snp_shared, snp_flush;
   logic [DW-1:0] snp_data;

   always #4 clk = ~clk;

   mesi_snoop_ctrl #(.ADDR_W(AW), .DATA_W(DW), .LINES(NL)) u_dut (
      .clk(clk), .rst_n(rst_n),
      .cpu_req_i(cpu_req), .cpu_we_i(cpu_we), .cpu_addr_i(cpu_addr), .cpu_wdata_i(cpu_wdata),
      .cpu_done_o(cpu_done), .cpu_rdata_o(cpu_rdata),
      .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_cmd_o(bus_cmd), .bus_addr_o(bus_addr),
      .bus_wdata_o(bus_wdata), .bus_ack_i(bus_ack), .bus_rdata_i(bus_rdata),
      .bus_shared_i(bus_shared),
      .snp_valid_i(snp_valid), .snp_cmd_i(snp_cmd), .snp_addr_i(snp_addr),
      .snp_shared_o(snp_shared), .snp_flush_o(snp_flush), .snp_data_o(snp_data)
   );

   // reference model: 0 I, 1 S, 2 E, 3 M
   logic [1:0]    r_st   [NL];
   logic [TW-1:0] r_tag  [NL];
   logic [DW-1:0] r_data [NL];
   logic [DW-1:0] mem    [1<<AW];

   int  n_chk = 0, n_bad = 0;
   bit  finished = 1'b0;

   logic [1:0]    e_cmd  [2];
   logic [AW-1:0] e_addr [2];
   logic [DW-1:0] e_dat  [2];
   int            e_n, o_n;

   task automatic chk(input bit ok, input string rq, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
      end
   endtask

   function automatic logic [DW-1:0] mem_init(input int a);
      return (32'(a) * 32'h9E3779B1) ^ 32'h5A5A_0F0F;
   endfunction

   // snoop effect on the model; returns expected answers
   task automatic model_snoop(input logic [1:0] cmd, input logic [AW-1:0] a,
                              output bit sh, output bit fl, output logic [DW-1:0] dt);
      int i;
      bit hit;
      i   = int'(a[IW-1:0]);
      hit = (r_st[i] != 2'd0) && (r_tag[i] == a[AW-1:IW]);
      sh  = hit && (cmd == 2'b01);
      fl  = hit && (cmd != 2'b00) && (r_st[i] == 2'd3);
      dt  = fl ? r_data[i] : '0;
      if (fl) mem[a] = r_data[i];
      if (hit && cmd == 2'b01) r_st[i] = 2'd1;
      if (hit && cmd == 2'b10) r_st[i] = 2'd0;
   endtask

   task automatic snoop_op(input logic [1:0] cmd, input logic [AW-1:0] a, input string rq);
      bit sh, fl;
      logic [DW-1:0] dt;
      @(negedge clk);
      snp_valid = 1'b1; snp_cmd = cmd; snp_addr = a;
      model_snoop(cmd, a, sh, fl, dt);
      #1;
      chk(snp_shared == sh, rq, "snoop shared", 64'(snp_shared), 64'(sh));
      chk(snp_flush == fl, rq, "snoop flush", 64'(snp_flush), 64'(fl));
      if (fl) chk(snp_data == dt, rq, "flush data", 64'(snp_data), 64'(dt));
      @(negedge clk);
      snp_valid = 1'b0; snp_cmd = 2'b00;
   endtask

   task automatic cpu_op(input bit we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                         input bit shr, input bit with_snp, input string rq);
      int i, cyc;
      bit hit, got, sh, fl;
      logic [DW-1:0] exp_rd, dt;
      i = int'(a[IW-1:0]);
      if (with_snp) model_snoop(2'b01, a, sh, fl, dt);
      hit = (r_st[i] != 2'd0) && (r_tag[i] == a[AW-1:IW]);
      e_n = 0; o_n = 0;
      exp_rd = '0;
      if (hit && (!we || r_st[i] >= 2'd2)) begin
         exp_rd = r_data[i];
         if (we) begin r_st[i] = 2'd3; r_data[i] = wd; end
      end else begin
         if (r_st[i] == 2'd3 && r_tag[i] != a[AW-1:IW]) begin
            e_cmd[0] = 2'b11; e_addr[0] = {r_tag[i], a[IW-1:0]}; e_dat[0] = r_data[i];
            mem[{r_tag[i], a[IW-1:0]}] = r_data[i];
            e_n = 1;
         end
         e_cmd[e_n] = we ? 2'b10 : 2'b01; e_addr[e_n] = a; e_dat[e_n] = '0;
         e_n++;
         exp_rd    = mem[a];
         r_tag[i]  = a[AW-1:IW];
         r_st[i]   = we ? 2'd3 : (shr ? 2'd1 : 2'd2);
         r_data[i] = we ? wd : mem[a];
      end
      @(negedge clk);
      cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
      if (with_snp) begin
         snp_valid = 1'b1; snp_cmd = 2'b01; snp_addr = a;
         #1;
         chk(snp_shared == sh, "R11", "conflict snoop shared", 64'(snp_shared), 64'(sh));
      end
      got = 1'b0;
      for (cyc = 0; cyc < 64 && !got; cyc++) begin
         @(negedge clk);
         if (cyc == 0) begin snp_valid = 1'b0; snp_cmd = 2'b00; end
         bus_gnt = bus_req;
         if (bus_ack) begin
            bus_ack = 1'b0;
         end else if (bus_cmd != 2'b00) begin
            if (o_n < e_n) begin
               chk(bus_cmd == e_cmd[o_n], rq, "bus command", 64'(bus_cmd), 64'(e_cmd[o_n]));
               chk(bus_addr == e_addr[o_n], rq, "bus address", 64'(bus_addr), 64'(e_addr[o_n]));
               if (e_cmd[o_n] == 2'b11)
                  chk(bus_wdata == e_dat[o_n], "R8", "writeback data", 64'(bus_wdata), 64'(e_dat[o_n]));
            end
            o_n++;
            bus_ack = 1'b1; bus_rdata = mem[bus_addr]; bus_shared = shr;
         end
         if (cpu_done) got = 1'b1;
      end
      chk(got, rq, "completion", 64'(got), 64'd1);
      cpu_req = 1'b0; bus_gnt = 1'b0; bus_ack = 1'b0;
      chk(o_n == e_n, rq, "transaction count", 64'(o_n), 64'(e_n));
      if (!we && got) chk(cpu_rdata == exp_rd, rq, "read data", 64'(cpu_rdata), 64'(exp_rd));
      @(negedge clk);
      chk(!cpu_done, "R9", "done pulse width", 64'(cpu_done), 64'd0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog expired actual=running expected=done");
         $display("test done: total=%0d bad=%0d", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] ra, pa, pb, pc, pd, pe;
      int unsigned sd;
      for (int k = 0; k < (1<<AW); k++) mem[k] = mem_init(k);
      for (int k = 0; k < NL; k++) begin r_st[k] = 2'd0; r_tag[k] = '0; r_data[k] = '0; end
      sd = $urandom(32'd424242);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1: reset state
      chk(!cpu_done, "R1", "done after reset", 64'(cpu_done), 64'd0);
      chk(!bus_req, "R1", "bus_req after reset", 64'(bus_req), 64'd0);
      snoop_op(2'b01, 10'h012, "R1");
      snoop_op(2'b10, 10'h3F5, "R1");

      pa = {7'h05, 3'd2};
      cpu_op(1'b0, pa, '0, 1'b0, 1'b0, "R2");          // miss, exclusive fill
      cpu_op(1'b0, pa, '0, 1'b0, 1'b0, "R2");          // read hit, no traffic
      cpu_op(1'b1, pa, 32'hDEAD_0001, 1'b0, 1'b0, "R3"); // E -> M silent
      cpu_op(1'b1, pa, 32'hDEAD_0002, 1'b0, 1'b0, "R3"); // M hit silent
      snoop_op(2'b01, pa, "R5");                         // flush, -> S
      cpu_op(1'b1, pa, 32'hDEAD_0003, 1'b0, 1'b0, "R4"); // S write -> RDX
      snoop_op(2'b10, pa, "R6");                         // flush, -> I
      cpu_op(1'b0, pa, '0, 1'b1, 1'b0, "R2");          // shared fill
      snoop_op(2'b10, pa, "R6");                         // S invalidated, no flush
      cpu_op(1'b0, pa, '0, 1'b0, 1'b0, "R2");          // refill exclusive
      snoop_op(2'b01, pa, "R7");                         // E -> S, shared
      cpu_op(1'b1, pa, 32'hDEAD_0004, 1'b0, 1'b0, "R4"); // must ask ownership

      pb = {7'h11, 3'd5}; pc = {7'h22, 3'd5}; pd = {7'h33, 3'd5};
      cpu_op(1'b1, pb, 32'hBEEF_0005, 1'b0, 1'b0, "R4"); // write miss
      cpu_op(1'b0, pc, '0, 1'b0, 1'b0, "R8");          // WB of dirty victim, then fill
      cpu_op(1'b0, pd, '0, 1'b0, 1'b0, "R8");          // clean victim dropped
      cpu_op(1'b0, pb, '0, 1'b1, 1'b0, "R8");          // written-back value from memory

      pe = {7'h40, 3'd6};
      cpu_op(1'b0, pe, '0, 1'b0, 1'b0, "R11");
      cpu_op(1'b1, pe, 32'hCAFE_0006, 1'b0, 1'b1, "R11"); // snoop wins, RDX follows
      snoop_op(2'b01, pe, "R11");

      // random mix
      for (int k = 0; k < 400; k++) begin
         int unsigned r;
         r  = $urandom % 10;
         ra = {5'd0, 2'($urandom % 4), 3'($urandom % 8)};
         if (r < 4)      cpu_op(1'b0, ra, '0, 1'($urandom % 2), 1'b0, "R2");
         else if (r < 7) cpu_op(1'b1, ra, $urandom, 1'($urandom % 2), 1'b0, "R4");
         else if (r < 9) snoop_op(2'b01, ra, "R7");
         else            snoop_op(2'b10, ra, "R6");
      end
      // R10 and R9 protocol checks ride on every op above

      finished = 1'b1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
   end
endmodule